// File: doc/BRIEF.md
# Reference-Windowed Clock Frequency Meter

This block measures the frequency of a clock whose rate is unknown by counting its cycles during a gate of fixed length. The gate length is expressed in cycles of a trusted reference clock. Software first issues a clear pulse. It then raises the start request together with a window length. When the result is valid, it computes the measured rate as reference rate × count ÷ window length.

The gate is generated in the reference domain and crosses into the measured domain through a two-flop synchronizer. The cycle counter runs on the measured clock and freezes when the gate falls. The measured domain sends its view of the gate back to the reference domain through a second two-flop synchronizer. When that returned gate falls, the frozen count is captured into the result register and the valid flag rises. The result holds until the next clear, so two reads taken some time apart return the same value. Until the flag is up the result reads zero, which tells software that a measurement is still in progress.

Top module: `freq_meter`

## Requirements
- R1: After reset, `count_valid` is 0 and `count_out` is 0.
- R2: A measurement holds the gate open for exactly W reference cycles. The result equals W × Fmeas ÷ Fref within ±2 counts.
- R3: A `window_len` of 0 selects the default window of `DEF_WIN` (100) reference cycles.
- R4: Once `count_valid` rises, `count_out` stays stable until `clear`. Two reads taken apart return the same value.
- R5: The measured-domain counter saturates at 2^CNT_W − 1 and does not wrap. A result that overflows reads all ones.
- R6: The window length is latched when the measurement starts. Changes to `window_len` while it runs have no effect, and `enable` held high after completion does not start another measurement.
- R7: A `clear` pulse drops `count_valid` and zeroes `count_out` on the next cycle. A later `enable` starts a fresh measurement.
- R8: While `count_valid` is 0, `count_out` reads 0.
- R9: A `clear` during a running measurement aborts it. A measurement started afterwards returns a correct result and is not polluted by the aborted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| ref_rst_n | input | 1 | Active-low reset, reference domain |
| meas_clk | input | 1 | Clock being measured |
| meas_rst_n | input | 1 | Active-low reset, measured domain |
| clear | input | 1 | Synchronous clear pulse (reference domain) |
| enable | input | 1 | Start request (level, reference domain) |
| window_len | input | WIN_W | Window in reference cycles, 0 selects default |
| count_out | output | CNT_W | Frozen measured-cycle count |
| count_valid | output | 1 | Result captured and stable |

## Verification
The bench measures fast and slow measured clocks against the expected ratio. A design whose gate is off by a cycle, or whose crossing loses the count, lands outside the ±2 tolerance. The overflow case drives more edges than the counter can hold; a wrapping counter would report a small number instead of all ones. An abort with a clear followed at once by a restart catches a counter that is not re-zeroed, which would report the two runs added together. Changing the window mid-run catches a design that samples the field live, and that design would report a count several times too large.

// File: rtl/freq_meter.sv
module freq_meter #(
  parameter int CNT_W   = 24,
  parameter int WIN_W   = 16,
  parameter int DEF_WIN = 100
) (
  input  logic             ref_clk,
  input  logic             ref_rst_n,
  input  logic             meas_clk,
  input  logic             meas_rst_n,
  input  logic             clear,
  input  logic             enable,
  input  logic [WIN_W-1:0] window_len,
  output logic [CNT_W-1:0] count_out,
  output logic             count_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [WIN_W-1:0] WIN_DEF = WIN_W'(DEF_WIN);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_WAIT, S_HOLD} st_t;

  st_t              st;
  logic [WIN_W-1:0] win_len, win_cnt;
  logic             gate_r, seen;
  logic             echo_1, echo_s;

  logic             gate_1, gate_s, gate_d;
  logic [CNT_W-1:0] cnt_m;

  wire [WIN_W-1:0] win_sel = (window_len == '0) ? WIN_DEF : window_len;

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      echo_1 <= 1'b0;
      echo_s <= 1'b0;
    end else begin
      echo_1 <= gate_d;
      echo_s <= echo_1;
    end
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) begin
      st          <= S_IDLE;
      win_len     <= '0;
      win_cnt     <= '0;
      gate_r      <= 1'b0;
      seen        <= 1'b0;
      count_out   <= '0;
      count_valid <= 1'b0;
    end else if (clear) begin
      st          <= S_IDLE;
      gate_r      <= 1'b0;
      seen        <= 1'b0;
      count_out   <= '0;
      count_valid <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (enable && !echo_s) begin
          win_len <= win_sel;
          win_cnt <= WIN_W'(1);
          gate_r  <= 1'b1;
          seen    <= 1'b0;
          st      <= S_RUN;
        end
        S_RUN: begin
          if (echo_s) seen <= 1'b1;
          if (win_cnt == win_len) begin
            gate_r <= 1'b0;
            st     <= S_WAIT;
          end else begin
            win_cnt <= win_cnt + WIN_W'(1);
          end
        end
        S_WAIT: begin
          if (echo_s) seen <= 1'b1;
          else if (seen) begin
            count_out   <= cnt_m;
            count_valid <= 1'b1;
            st          <= S_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge meas_clk or negedge meas_rst_n) begin
    if (!meas_rst_n) begin
      gate_1 <= 1'b0;
      gate_s <= 1'b0;
      gate_d <= 1'b0;
      cnt_m  <= '0;
    end else begin
      gate_1 <= gate_r;
      gate_s <= gate_1;
      gate_d <= gate_s;
      if (gate_s && !gate_d)
        cnt_m <= '0;
      else if (gate_d && cnt_m != CNT_MAX)
        cnt_m <= cnt_m + CNT_W'(1);
    end
  end
endmodule

// File: rtl/freq_meter_chk.sv
module freq_meter_chk #(
  parameter int CNT_W = 24
) (
  input logic             ref_clk,
  input logic             ref_rst_n,
  input logic             meas_clk,
  input logic             meas_rst_n,
  input logic             clear,
  input logic [CNT_W-1:0] count_out,
  input logic             count_valid,
  input logic [CNT_W-1:0] cnt_m,
  input logic             gate_s,
  input logic             gate_d
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  a_r4_result_frozen: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (count_valid && !clear) |=> (count_valid && $stable(count_out)));

  a_r8_zero_until_valid: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !count_valid |-> (count_out == '0));

  a_r7_clear_drops: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    clear |=> (!count_valid && count_out == '0));

  a_r5_saturate: assert property (@(posedge meas_clk) disable iff (!meas_rst_n)
    (gate_d && cnt_m == CNT_MAX) |=> (cnt_m == CNT_MAX));

  a_r5_no_wrap: assert property (@(posedge meas_clk) disable iff (!meas_rst_n)
    gate_d |=> (cnt_m >= $past(cnt_m)));

  a_r4_meas_frozen: assert property (@(posedge meas_clk) disable iff (!meas_rst_n)
    (!gate_d && !gate_s) |=> $stable(cnt_m));
endmodule

bind freq_meter freq_meter_chk #(.CNT_W(CNT_W)) chk_i (
  .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .meas_clk(meas_clk),
  .meas_rst_n(meas_rst_n), .clear(clear), .count_out(count_out),
  .count_valid(count_valid), .cnt_m(cnt_m), .gate_s(gate_s), .gate_d(gate_d)
);

// File: tb/freq_meter_tb_top.sv
`timescale 1ns/1ps
module freq_meter_tb_top;
  localparam int CNT_W = 10;
  localparam int WIN_W = 12;

  logic ref_clk = 0, meas_clk = 0;
  logic ref_rst_n = 0, meas_rst_n = 0;
  logic clear = 0, enable = 0;
  logic [WIN_W-1:0] window_len = '0;
  logic [CNT_W-1:0] count_out;
  logic count_valid;
  real meas_half = 2.0;
  int errors = 0, checks = 0, cycles = 0;

  freq_meter #(.CNT_W(CNT_W), .WIN_W(WIN_W), .DEF_WIN(100)) dut_i (
    .ref_clk(ref_clk), .ref_rst_n(ref_rst_n), .meas_clk(meas_clk),
    .meas_rst_n(meas_rst_n), .clear(clear), .enable(enable),
    .window_len(window_len), .count_out(count_out), .count_valid(count_valid));

  always #5 ref_clk = ~ref_clk;
  always #(meas_half) meas_clk = ~meas_clk;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge ref_clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d cycles exp<=150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  task automatic do_clear();
    clear = 1; tick(1); clear = 0;
  endtask

  task automatic wait_valid(input string tag);
    int t = 0;
    while (!count_valid && t < 5000) begin tick(1); t++; end
    chk(count_valid, tag, count_valid, 1);
  endtask

  task automatic measure(input int w, input real half, input string tag);
    int exp, wl, a, b;
    meas_half = half;
    wl = (w == 0) ? 100 : w;
    exp = (wl * 10) / int'(2.0 * half);
    if (exp > 1023) exp = 1023;
    do_clear();
    chk(!count_valid && count_out == 0, {tag, " R8 in progress"}, count_out, 0);
    window_len = WIN_W'(w); enable = 1;
    wait_valid(tag);
    a = count_out;
    chk(a >= exp - 2 && a <= exp + 2, tag, a, exp);
    tick(50);
    b = count_out;
    chk(a == b && count_valid, {tag, " R4 reread"}, b, a);
    enable = 0;
  endtask

  task automatic t_reset();
    tick(1);
    chk(count_valid == 0, "R1 valid", count_valid, 0);
    chk(count_out == 0, "R1 count", count_out, 0);
  endtask

  task automatic t_ratio();
    measure(100, 2.0, "R2 fast");
    measure(200, 12.5, "R2 slow");
    measure(300, 3.0, "R2 mid");
  endtask

  task automatic t_default();
    measure(0, 4.0, "R3 default window");
  endtask

  task automatic t_saturate();
    measure(1000, 2.0, "R5 saturate");
  endtask

  task automatic t_ignore();
    int a;
    meas_half = 2.0;
    do_clear();
    window_len = 12'd100; enable = 1;
    tick(5);
    window_len = 12'd900;
    wait_valid("R6 valid");
    a = count_out;
    chk(a >= 248 && a <= 252, "R6 window latched", a, 250);
    tick(200);
    chk(count_valid && count_out == a, "R6 enable held no restart", count_out, a);
    enable = 0;
  endtask

  task automatic t_clear();
    do_clear();
    tick(1);
    chk(!count_valid && count_out == 0, "R7 clear", count_out, 0);
    measure(100, 2.0, "R7 fresh after clear");
  endtask

  task automatic t_abort();
    int a;
    meas_half = 2.0;
    do_clear();
    window_len = 12'd1000; enable = 1;
    tick(300);
    enable = 0;
    do_clear();
    chk(!count_valid && count_out == 0, "R9 abort", count_out, 0);
    window_len = 12'd100; enable = 1;
    wait_valid("R9 valid");
    a = count_out;
    chk(a >= 248 && a <= 252, "R9 restart count", a, 250);
    enable = 0;
  endtask

  initial begin
    tick(3);
    ref_rst_n = 1; meas_rst_n = 1;
    t_reset();
    t_ratio();
    t_default();
    t_saturate();
    t_ignore();
    t_clear();
    t_abort();
    finish_run();
  end
endmodule